// File: doc/BRIEF.md
# Level-Sensitive 32-Source Interrupt Controller

This block gathers 32 level-sensitive interrupt lines from devices into one level-sensitive request to the processor. Software manages a 32-bit enable mask through three write-only registers: one that sets chosen enable bits, one that clears chosen enable bits, and one that clears the whole mask at once. A fourth, read-only register returns the pending word. The pending word is the current input levels ANDed with the enable mask, so every enabled, active source is visible in a single read.

The register bus is a simple single-cycle interface. It has a 12-bit byte offset inside a 4 KiB window, a write strobe with write data, and a read strobe. Read data is registered and appears on the cycle after the strobe. The address decoder of the system selects the window. Bus data uses big-endian lane order: the most significant byte of a register travels on the lowest-addressed byte lane. The processor request rises and falls in the same cycle as the inputs and the mask, so it drops as soon as no enabled source is active.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable mask is all zero, `irq_out` is low and `bus_rdata` is zero.
- R2: A write at offset 0x010 sets each enable bit whose mask bit is 1 and leaves the other enable bits unchanged.
- R3: A write at offset 0x00C clears each enable bit whose mask bit is 1 and leaves the other enable bits unchanged.
- R4: A write of any value at offset 0x008 clears every enable bit.
- R5: A read at offset 0x004 returns, on the cycle after the read strobe, the input levels ANDed with the enable mask as they stood in the strobe cycle. Bit n refers to input n, and several bits may be set at once.
- R6: `irq_out` is high exactly when at least one enabled input is high, with no register delay.
- R7: Bus data is big-endian. Register bits 31:24 travel on `bus_wdata`/`bus_rdata` bits 7:0, and register bits 7:0 travel on bus bits 31:24. Each byte keeps its own bit order.
- R8: A read at any offset other than 0x004 returns zero. This includes the write-only offsets 0x008, 0x00C and 0x010.
- R9: A write at any offset other than 0x008, 0x00C or 0x010 leaves the enable mask unchanged. This includes offset 0x004 and unaligned offsets.
- R10: `bus_rdata` changes only in the cycle after a read strobe and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset inside the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data, big-endian lanes |
| irq_in | input | 32 | Level-sensitive device interrupt lines |
| irq_out | output | 1 | Level-sensitive request to the processor |

## Verification
The hardest case to reach from the ports is a proof that a write to an undecoded or read-only offset did not touch the mask. The mask has no read port, so the bench first drives all inputs high. It then writes all-ones to the offset under test and reads the pending word back, together with `irq_out`. This shows that no enable bit appeared. Lane order is checked with raw bus words that are not symmetric under a byte swap, so a missing or doubled swap is visible.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int WIN_BITS = 12;

    localparam logic [WIN_BITS-1:0] OFF_PEND   = 12'h004;
    localparam logic [WIN_BITS-1:0] OFF_CLRALL = 12'h008;
    localparam logic [WIN_BITS-1:0] OFF_CLR    = 12'h00C;
    localparam logic [WIN_BITS-1:0] OFF_SET    = 12'h010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_CLRALL,
        SEL_CLR,
        SEL_SET
    } reg_sel_e;
endpackage

// File: rtl/lic_lane_swap.sv
// Maps a register word to bus lanes (or back); the mapping is its own inverse.
module lic_lane_swap #(
    parameter int W          = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        if (BIG_ENDIAN) begin : g_swap
            assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
        end else begin : g_pass
            assign dout[8*b +: 8] = din[8*b +: 8];
        end
    end
endmodule

// File: rtl/lic_decode.sv
module lic_decode
    import lic_pkg::*;
(
    input  logic [WIN_BITS-1:0] addr,
    output reg_sel_e            sel
);
    always_comb begin
        unique case (addr)
            OFF_PEND:   sel = SEL_PEND;
            OFF_CLRALL: sel = SEL_CLRALL;
            OFF_CLR:    sel = SEL_CLR;
            OFF_SET:    sel = SEL_SET;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/lic_enable_reg.sv
module lic_enable_reg
    import lic_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] en
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (sel)
                SEL_CLRALL: st_d.en = '0;
                SEL_CLR:    st_d.en = st_q.en & ~mask;
                SEL_SET:    st_d.en = st_q.en | mask;
                default:    st_d.en = st_q.en;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/lic_read_port.sv
module lic_read_port
    import lic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  reg_sel_e     sel,
    input  logic [W-1:0] pend_bus,
    output logic [W-1:0] rdata
);
    typedef struct packed {
        logic [W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.rdata = (sel == SEL_PEND) ? pend_bus : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int N_SRC      = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIN_BITS-1:0] bus_addr,
    input  logic                bus_wr,
    input  logic [N_SRC-1:0]    bus_wdata,
    input  logic                bus_rd,
    output logic [N_SRC-1:0]    bus_rdata,
    input  logic [N_SRC-1:0]    irq_in,
    output logic                irq_out
);
    reg_sel_e         sel;
    logic [N_SRC-1:0] wmask;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] pend_bus;

    lic_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    lic_lane_swap #(.W(N_SRC), .BIG_ENDIAN(BIG_ENDIAN)) u_wswap (
        .din  (bus_wdata),
        .dout (wmask)
    );

    lic_enable_reg #(.N_SRC(N_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .sel   (sel),
        .mask  (wmask),
        .en    (en_q)
    );

    assign pend    = irq_in & en_q;
    assign irq_out = |pend;

    lic_lane_swap #(.W(N_SRC), .BIG_ENDIAN(BIG_ENDIAN)) u_rswap (
        .din  (pend),
        .dout (pend_bus)
    );

    lic_read_port #(.W(N_SRC)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .sel      (sel),
        .pend_bus (pend_bus),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
    parameter int N_SRC      = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [11:0]      bus_addr,
    input logic             bus_wr,
    input logic [N_SRC-1:0] bus_wdata,
    input logic             bus_rd,
    input logic [N_SRC-1:0] bus_rdata,
    input logic [N_SRC-1:0] irq_in,
    input logic             irq_out,
    input logic [N_SRC-1:0] en_q
);
    function automatic logic [N_SRC-1:0] lanes(input logic [N_SRC-1:0] v);
        logic [N_SRC-1:0] r;
        for (int b = 0; b < N_SRC/8; b++) begin
            r[8*b +: 8] = BIG_ENDIAN ? v[8*(N_SRC/8-1-b) +: 8] : v[8*b +: 8];
        end
        return r;
    endfunction

    logic is_set, is_clr, is_all, is_pend;
    assign is_pend = (bus_addr == 12'h004);
    assign is_all  = (bus_addr == 12'h008);
    assign is_clr  = (bus_addr == 12'h00C);
    assign is_set  = (bus_addr == 12'h010);

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_set) |=> ((en_q & $past(lanes(bus_wdata))) == $past(lanes(bus_wdata))));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_clr) |=> ((en_q & $past(lanes(bus_wdata))) == '0));

    // R4
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_all) |=> (en_q == '0));

    // R5
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_pend) |=> (bus_rdata == lanes($past(irq_in & en_q))));

    // R6
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out);

    // R8
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_pend) |=> (bus_rdata == '0));

    // R9
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !is_set && !is_clr && !is_all) |=> $stable(en_q));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind lvl_irq_ctrl lic_checker #(.N_SRC(N_SRC), .BIG_ENDIAN(BIG_ENDIAN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .en_q      (en_q)
);

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] be(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        irq_in = '1;
        bus_read(12'h004, r);
        check("R1 mask empty", r, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] r;
        irq_in = '1;
        bus_write(12'h010, be(32'h0000_0005));
        bus_read(12'h004, r);
        check("R2 set", r, be(32'h0000_0005));
        bus_write(12'h010, be(32'h0000_0100));
        bus_read(12'h004, r);
        check("R2 keep", r, be(32'h0000_0105));
    endtask

    task automatic t_clear();
        logic [31:0] r;
        bus_write(12'h00C, be(32'h0000_0004));
        bus_read(12'h004, r);
        check("R3 clear", r, be(32'h0000_0101));
    endtask

    task automatic t_clear_all();
        logic [31:0] r;
        bus_write(12'h00C + 12'h0, be(32'h0));
        bus_write(12'h008, 32'h0);
        bus_read(12'h004, r);
        check("R4 clear all", r, 32'h0);
        check("R4 irq_out", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_irq_level();
        logic [31:0] r;
        irq_in = '0;
        bus_write(12'h010, be(32'h0000_0008));
        #1 check("R6 idle", {31'b0, irq_out}, 32'h0);
        irq_in = 32'h0000_0008;
        #1 check("R6 rise", {31'b0, irq_out}, 32'h1);
        irq_in = 32'h0000_0010;
        #1 check("R6 masked", {31'b0, irq_out}, 32'h0);
        irq_in = '1;
        bus_write(12'h010, be(32'h8000_0011));
        bus_read(12'h004, r);
        check("R5 multi", r, be(32'h8000_0019));
        irq_in = 32'h8000_0001;
        bus_read(12'h004, r);
        check("R5 follows inputs", r, be(32'h8000_0001));
        bus_write(12'h008, 32'hFFFF_FFFF);
        #1 check("R6 drop", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_endian();
        logic [31:0] r;
        bus_write(12'h010, 32'h0000_0001);
        irq_in = 32'h0100_0000;
        #1 check("R7 lane0 is bit24", {31'b0, irq_out}, 32'h1);
        irq_in = 32'h0000_0001;
        #1 check("R7 not bit0", {31'b0, irq_out}, 32'h0);
        irq_in = '1;
        bus_read(12'h004, r);
        check("R7 read lanes", r, 32'h0000_0001);
        bus_write(12'h008, 32'h0);
    endtask

    task automatic t_undef_read();
        logic [31:0] r;
        irq_in = '1;
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_read(12'h008, r); check("R8 rd 0x008", r, 32'h0);
        bus_read(12'h00C, r); check("R8 rd 0x00C", r, 32'h0);
        bus_read(12'h010, r); check("R8 rd 0x010", r, 32'h0);
        bus_read(12'h000, r); check("R8 rd 0x000", r, 32'h0);
        bus_read(12'h014, r); check("R8 rd 0x014", r, 32'h0);
        bus_read(12'h005, r); check("R8 rd 0x005", r, 32'h0);
        bus_write(12'h008, 32'h0);
    endtask

    task automatic t_undef_write();
        logic [31:0] r;
        irq_in = '1;
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_write(12'h011, 32'hFFFF_FFFF);
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        bus_read(12'h004, r);
        check("R9 no effect", r, 32'h0);
        check("R9 irq_out", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        irq_in = '1;
        bus_write(12'h010, be(32'h0000_00F0));
        bus_read(12'h004, r);
        irq_in = '0;
        repeat (3) @(negedge clk);
        check("R10 hold", bus_rdata, be(32'h0000_00F0));
        bus_write(12'h008, 32'h0);
        check("R10 hold over write", bus_rdata, be(32'h0000_00F0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_clear_all();
        t_irq_level();
        t_endian();
        t_undef_read();
        t_undef_write();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule